// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of trace frames into an on-chip RAM that is treated as a ring. Frames offered on the input port are accepted while capture is enabled, pass through a one-frame formatter stage, and are then written at the write pointer, which steps forward and wraps around the end of the RAM. Software uses a nine-entry register port to see the block's identity and geometry, program the pointers, the post-trigger count and the control word, poll the status flags, and drain the captured frames one by one through a data register that advances its own pointer on every read.

A trigger input marks the point of interest. Once a trigger has been seen, a further programmed number of frames is stored, after which acquisition stops by itself and a completion flag rises. Without a trigger the ring keeps overwriting its oldest entries until software disables capture. A Full flag tells software whether the oldest valid frame sits at entry 0 (flag clear, valid frames are 0 up to write pointer minus one) or at the write pointer (flag set, every entry valid).

Top module: `trace_ring_buffer`

## Requirements
- R1: Register reads return, by address: 0 a fixed identity constant (default 0x54520100), 1 the RAM depth in frames, 2 the frame width in bits, 3 status, 4 RAM data, 5 read pointer, 6 write pointer, 7 trigger count, 8 control. A read issued in one cycle presents its value on the read data port from the next clock edge and holds it until the next read.
- R2: Writes to addresses 0 to 3 have no effect on any register.
- R3: While control bit 0 (enable) is set, each frame presented with its valid strobe is stored at the write pointer, which then increments modulo the depth; writing 0 to control stops further acceptance, and frames offered while disabled are dropped.
- R4: Each read of address 4 returns the entry at the read pointer and then increments the read pointer modulo the depth.
- R5: Status bit 0 (Full) sets when a frame is stored in the last RAM entry and stays set until a new capture starts, a new capture being a control write that sets bit 0 while enable is clear.
- R6: Status bit 1 (Triggered) sets when the trigger input is high while enable is set, and stays set until a new capture starts.
- R7: After the cycle in which the trigger is seen, exactly the programmed trigger count of further frames is stored, the counter (address 7) decrementing once per stored frame; then no more frames are stored and status bit 2 (AcquisitionComplete) sets. A count of 0 stores no frame after the trigger cycle.
- R8: Status bit 3 (FormatterEmpty) is low while an accepted frame waits in the formatter stage and high once it has been written, so it can lag the acceptance by one cycle.
- R9: The read and write pointers (addresses 5 and 6) are writable; only the low log2(depth) bits of the written value are kept.
- R10: Control bit 1 selects demultiplexed input mode; it is shown on the demuxMode output and read back at address 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| frameValid | input | 1 | A trace frame is offered this cycle |
| frameData | input | FRAME_W | Trace frame contents |
| trigIn | input | 1 | Trigger event this cycle |
| regAddr | input | 4 | Register address, 0 to 8 |
| regWrData | input | 32 | Register write value |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regRdData | output | 32 | Register read value, valid one cycle after the strobe |
| demuxMode | output | 1 | Demultiplexed input mode selected |

## Verification
A register write takes effect at the clock edge that samples it and a read returns its value one edge after the strobe, so the bench drives strobes on the falling edge and samples read data on the following falling edge. An accepted frame reaches the RAM one edge after acceptance, which is why the bench leaves a few idle cycles after each stream before reading pointers, status or RAM contents, and why the FormatterEmpty check issues its status read exactly one cycle after the frame. The trigger window is checked by a cycle-by-cycle model of acceptance in the bench that predicts which frame indices land in the ring.

// File: rtl/trc_pkg.sv
package trc_pkg;

  // register addresses; the order is what software decodes
  typedef enum logic [3:0] {
    REG_ID      = 4'd0,
    REG_DEPTH   = 4'd1,
    REG_WIDTH   = 4'd2,
    REG_STATUS  = 4'd3,
    REG_DATA    = 4'd4,
    REG_RDPTR   = 4'd5,
    REG_WRPTR   = 4'd6,
    REG_TRIGCNT = 4'd7,
    REG_CTRL    = 4'd8
  } reg_sel_e;

  localparam int STAT_FULL  = 0;
  localparam int STAT_TRIG  = 1;
  localparam int STAT_DONE  = 2;
  localparam int STAT_EMPTY = 3;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic acceptFrame;
    logic loadWrPtr;
    logic loadRdPtr;
    logic advanceRd;
  } dp_cmd_t;

endpackage

// File: rtl/trc_datapath.sv
module trc_datapath
  import trc_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int FRAME_W = 24,
  parameter int PTR_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dp_cmd_t            cmd,
  input  logic [PTR_W-1:0]   ptrValue,
  input  logic [FRAME_W-1:0] frameData,
  output logic               pendValid,
  output logic               wrapEvent,
  output logic [PTR_W-1:0]   wrPtr,
  output logic [PTR_W-1:0]   rdPtr,
  output logic [FRAME_W-1:0] rdWord
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [FRAME_W-1:0] ring [DEPTH];
  logic [FRAME_W-1:0] pendData;
  logic [PTR_W-1:0]   wrNext;
  logic [PTR_W-1:0]   rdNext;

  assign wrNext    = (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
  assign rdNext    = (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
  assign wrapEvent = pendValid && (wrPtr == LAST);
  assign rdWord    = ring[rdPtr];

  // formatter stage: one frame of holding before the RAM
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendData  <= '0;
    end else begin
      pendValid <= cmd.acceptFrame;
      if (cmd.acceptFrame) pendData <= frameData;
    end
  end

  // ring storage, one write port per entry
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                          ring[gi] <= '0;
      else if (pendValid && (wrPtr == PTR_W'(gi)))        ring[gi] <= pendData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (cmd.loadWrPtr)      wrPtr <= ptrValue;
      else if (pendValid)     wrPtr <= wrNext;
      if (cmd.loadRdPtr)      rdPtr <= ptrValue;
      else if (cmd.advanceRd) rdPtr <= rdNext;
    end
  end

endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter int          FRAME_W  = 24,
  parameter int          PTR_W    = $clog2(DEPTH),
  parameter logic [31:0] ID_VALUE = 32'h5452_0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameValid,
  input  logic               trigIn,
  input  logic [3:0]         regAddr,
  input  logic [31:0]        regWrData,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic               pendValid,
  input  logic               wrapEvent,
  input  logic [PTR_W-1:0]   wrPtr,
  input  logic [PTR_W-1:0]   rdPtr,
  input  logic [FRAME_W-1:0] rdWord,
  output dp_cmd_t            cmd,
  output logic [PTR_W-1:0]   ptrValue,
  output logic [3:0]         statusBits,
  output logic               demuxMode,
  output logic [31:0]        regRdData
);

  logic        ctrlEn;
  logic        fullFlag;
  logic        trigFlag;
  logic        doneFlag;
  logic [31:0] trigCnt;
  logic [31:0] dataExt;
  logic [31:0] rdMux;
  logic        wrCtrl;
  logic        startCap;
  logic        cntZero;
  logic        accept;

  assign wrCtrl   = regWrEn && (regAddr == REG_CTRL);
  assign startCap = wrCtrl && regWrData[0] && !ctrlEn;
  assign cntZero  = (trigCnt == 32'd0);
  assign accept   = ctrlEn && frameValid && !doneFlag && !(trigFlag && cntZero);

  assign cmd.acceptFrame = accept;
  assign cmd.loadWrPtr   = regWrEn && (regAddr == REG_WRPTR);
  assign cmd.loadRdPtr   = regWrEn && (regAddr == REG_RDPTR);
  assign cmd.advanceRd   = regRdEn && (regAddr == REG_DATA);
  assign ptrValue        = regWrData[PTR_W-1:0];

  assign statusBits[STAT_FULL]  = fullFlag;
  assign statusBits[STAT_TRIG]  = trigFlag;
  assign statusBits[STAT_DONE]  = doneFlag;
  assign statusBits[STAT_EMPTY] = !pendValid;

  if (FRAME_W < 32) begin : g_pad
    assign dataExt = {{(32 - FRAME_W){1'b0}}, rdWord};
  end else begin : g_cut
    assign dataExt = rdWord[31:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn    <= 1'b0;
      demuxMode <= 1'b0;
    end else if (wrCtrl) begin
      ctrlEn    <= regWrData[0];
      demuxMode <= regWrData[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullFlag <= 1'b0;
      trigFlag <= 1'b0;
      doneFlag <= 1'b0;
    end else if (startCap) begin
      fullFlag <= 1'b0;
      trigFlag <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      if (wrapEvent)                    fullFlag <= 1'b1;
      if (ctrlEn && trigIn)             trigFlag <= 1'b1;
      if (ctrlEn && trigFlag && cntZero) doneFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     trigCnt <= '0;
    else if (regWrEn && (regAddr == REG_TRIGCNT))  trigCnt <= regWrData;
    else if (accept && trigFlag)                   trigCnt <= trigCnt - 32'd1;
  end

  always_comb begin
    unique case (regAddr)
      REG_ID:      rdMux = ID_VALUE;
      REG_DEPTH:   rdMux = 32'(DEPTH);
      REG_WIDTH:   rdMux = 32'(FRAME_W);
      REG_STATUS:  rdMux = {28'd0, statusBits};
      REG_DATA:    rdMux = dataExt;
      REG_RDPTR:   rdMux = 32'(rdPtr);
      REG_WRPTR:   rdMux = 32'(wrPtr);
      REG_TRIGCNT: rdMux = trigCnt;
      REG_CTRL:    rdMux = {30'd0, demuxMode, ctrlEn};
      default:     rdMux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        regRdData <= '0;
    else if (regRdEn) regRdData <= rdMux;
  end

endmodule

// File: rtl/trace_ring_buffer.sv
module trace_ring_buffer
  import trc_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter int          FRAME_W  = 24,
  parameter logic [31:0] ID_VALUE = 32'h5452_0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameValid,
  input  logic [FRAME_W-1:0] frameData,
  input  logic               trigIn,
  input  logic [3:0]         regAddr,
  input  logic [31:0]        regWrData,
  input  logic               regWrEn,
  input  logic               regRdEn,
  output logic [31:0]        regRdData,
  output logic               demuxMode
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  dp_cmd_t            cmd;
  logic [PTR_W-1:0]   ptrValue;
  logic               pendValid;
  logic               wrapEvent;
  logic [PTR_W-1:0]   wrPtr;
  logic [PTR_W-1:0]   rdPtr;
  logic [FRAME_W-1:0] rdWord;
  logic [3:0]         statusBits;

  trc_ctrl #(
    .DEPTH(DEPTH), .FRAME_W(FRAME_W), .PTR_W(PTR_W), .ID_VALUE(ID_VALUE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .trigIn(trigIn),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .pendValid(pendValid), .wrapEvent(wrapEvent), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .rdWord(rdWord), .cmd(cmd), .ptrValue(ptrValue), .statusBits(statusBits),
    .demuxMode(demuxMode), .regRdData(regRdData)
  );

  trc_datapath #(
    .DEPTH(DEPTH), .FRAME_W(FRAME_W), .PTR_W(PTR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .ptrValue(ptrValue), .frameData(frameData),
    .pendValid(pendValid), .wrapEvent(wrapEvent), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .rdWord(rdWord)
  );

endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       regAddr,
  input logic [31:0]      regWrData,
  input logic             regWrEn,
  input logic             regRdEn,
  input logic             pendValid,
  input logic             loadWr,
  input logic [PTR_W-1:0] wrPtr,
  input logic [PTR_W-1:0] rdPtr,
  input logic [3:0]       statusBits,
  input logic             demuxMode
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic ctrlSetWrite;
  assign ctrlSetWrite = regWrEn && (regAddr == 4'd8) && regWrData[0];

  // R3: every frame leaving the formatter moves the write pointer by one
  p_wrptr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && !loadWr) |=>
      (wrPtr == (($past(wrPtr) == LAST) ? '0 : $past(wrPtr) + 1'b1)));

  // R4: a data read moves the read pointer by one
  p_rdptr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && (regAddr == 4'd4) && !(regWrEn && (regAddr == 4'd5))) |=>
      (rdPtr == (($past(rdPtr) == LAST) ? '0 : $past(rdPtr) + 1'b1)));

  // R5: Full only clears on a capture start
  p_full_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statusBits[0] && !ctrlSetWrite) |=> statusBits[0]);

  // R6: Triggered only clears on a capture start
  p_trig_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statusBits[1] && !ctrlSetWrite) |=> statusBits[1]);

  // R7: nothing enters the formatter once acquisition is complete
  p_no_accept_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    statusBits[2] |=> !pendValid);

  // R10: mode output follows the control write
  p_demux_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr == 4'd8)) |=> (demuxMode == $past(regWrData[1])));

endmodule

bind trace_ring_buffer trc_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
  .regWrEn(regWrEn), .regRdEn(regRdEn), .pendValid(pendValid),
  .loadWr(cmd.loadWrPtr), .wrPtr(wrPtr), .rdPtr(rdPtr),
  .statusBits(statusBits), .demuxMode(demuxMode)
);

// File: tb/tb_trace_ring_buffer.sv
module tb_trace_ring_buffer;

  localparam int DEPTH = 16;
  localparam int FW    = 24;
  localparam logic [31:0] IDV = 32'h5452_0100;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          frameValid = 1'b0;
  logic [FW-1:0] frameData = '0;
  logic          trigIn = 1'b0;
  logic [3:0]    regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic          regWrEn = 1'b0;
  logic          regRdEn = 1'b0;
  logic [31:0]   regRdData;
  logic          demuxMode;

  trace_ring_buffer #(.DEPTH(DEPTH), .FRAME_W(FW), .ID_VALUE(IDV)) dut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameData(frameData),
    .trigIn(trigIn), .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regRdData(regRdData), .demuxMode(demuxMode)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // bench model of the ring, built from the requirements
  logic [FW-1:0] bmem [DEPTH];
  int  bWr, bCnt, frameIdx;
  bit  bFull, bTrig, bDone;

  function automatic logic [FW-1:0] frameVal(input int i);
    logic [31:0] v;
    v = i * 32'h0001_3579 + 32'h0000_A5A5;
    return v[FW-1:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic modelStart();
    bFull = 0; bTrig = 0; bDone = 0;
  endtask

  // offers n back-to-back frames; trigger pulsed with frame number trigAt
  task automatic stream(input int n, input int trigAt, input bit en);
    for (int k = 0; k < n; k++) begin
      bit acc, doneNext;
      @(negedge clk);
      frameValid = 1'b1;
      frameData  = frameVal(frameIdx);
      trigIn     = (k == trigAt);
      acc      = en && !bDone && !(bTrig && bCnt == 0);
      doneNext = bDone || (en && bTrig && bCnt == 0);
      if (acc) begin
        bmem[bWr] = frameVal(frameIdx);
        if (bWr == DEPTH - 1) bFull = 1;
        bWr = (bWr + 1) % DEPTH;
        if (bTrig) bCnt--;
      end
      bDone = doneNext;
      if (en && k == trigAt) bTrig = 1;
      frameIdx++;
    end
    @(negedge clk);
    frameValid = 1'b0; trigIn = 1'b0;
  endtask

  task automatic checkRing(input string req);
    logic [31:0] d;
    int start, n;
    start = bFull ? bWr : 0;
    n     = bFull ? DEPTH : bWr;
    regWr(4'd5, 32'(start));
    for (int k = 0; k < n; k++) begin
      regRd(4'd4, d);
      chk(req, d, 32'(bmem[(start + k) % DEPTH]));
    end
    regRd(4'd5, d);
    chk({req, " rdptr after drain"}, d, 32'((start + n) % DEPTH));
  endtask

  task automatic checkState(input string req);
    logic [31:0] d;
    regRd(4'd3, d);
    chk({req, " status"}, d, {28'd0, 1'b1, bDone, bTrig, bFull});
    regRd(4'd6, d);
    chk({req, " wrptr"}, d, 32'(bWr));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) bmem[i] = '0;
    bWr = 0; bCnt = 0; frameIdx = 0;
    modelStart();
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1: reset values and fixed registers
    regRd(4'd3, d); chk("R1 reset status", d, 32'h8);
    regRd(4'd0, d); chk("R1 id", d, IDV);
    regRd(4'd1, d); chk("R1 depth", d, 32'(DEPTH));
    regRd(4'd2, d); chk("R1 width", d, 32'(FW));
    regRd(4'd8, d); chk("R1 ctrl", d, 32'h0);
    regRd(4'd7, d); chk("R1 trigcnt", d, 32'h0);
    regRd(4'd5, d); chk("R1 rdptr", d, 32'h0);

    // R2: read-only registers ignore writes
    for (int a = 0; a < 4; a++) regWr(4'(a), 32'hFFFF_FFFF);
    regRd(4'd0, d); chk("R2 id after write", d, IDV);
    regRd(4'd1, d); chk("R2 depth after write", d, 32'(DEPTH));
    regRd(4'd2, d); chk("R2 width after write", d, 32'(FW));
    regRd(4'd3, d); chk("R2 status after write", d, 32'h8);

    // R3: frames while disabled are dropped
    stream(4, -1, 1'b0);
    idle(3);
    checkState("R3 disabled");

    // R3 R4: short capture without trigger
    regWr(4'd8, 32'h1); modelStart();
    stream(5, -1, 1'b1);
    regWr(4'd8, 32'h0);
    stream(2, -1, 1'b0);
    idle(3);
    checkState("R3 short capture");
    checkRing("R4 short drain");

    // R5 R4: wrap the ring
    regWr(4'd6, 32'h0); bWr = 0;
    regWr(4'd8, 32'h1); modelStart();
    stream(20, -1, 1'b1);
    regWr(4'd8, 32'h0);
    idle(3);
    checkState("R5 wrapped");
    checkRing("R4 wrapped drain");

    // R6 R7: trigger with post-count 3
    regWr(4'd7, 32'd3); bCnt = 3;
    regWr(4'd6, 32'h0); bWr = 0;
    regWr(4'd8, 32'h1); modelStart();
    stream(10, 2, 1'b1);
    idle(3);
    checkState("R6 R7 triggered");
    chk("R7 model frames stored", 32'(bWr), 32'd6);
    regRd(4'd7, d); chk("R7 trigcnt exhausted", d, 32'd0);
    checkRing("R7 post-trigger drain");
    regWr(4'd5, 32'(bWr));
    regRd(4'd4, d); chk("R7 entry past stop untouched", d, 32'(bmem[bWr]));

    // R7: zero post-count stops right after trigger cycle
    regWr(4'd8, 32'h0);
    regWr(4'd7, 32'd0); bCnt = 0;
    regWr(4'd6, 32'h0); bWr = 0;
    regWr(4'd8, 32'h1); modelStart();
    stream(4, 1, 1'b1);
    idle(3);
    checkState("R7 zero count");
    chk("R7 zero count frames", 32'(bWr), 32'd2);
    regWr(4'd8, 32'h0);

    // R9: pointer writes keep low bits
    regWr(4'd6, 32'h23); regRd(4'd6, d); chk("R9 wrptr mask", d, 32'h3);
    regWr(4'd5, 32'h1F); regRd(4'd5, d); chk("R9 rdptr mask", d, 32'hF);

    // R10: demux select
    regWr(4'd8, 32'h2);
    chk("R10 demux output", 32'(demuxMode), 32'd1);
    regRd(4'd8, d); chk("R10 ctrl readback", d, 32'h2);
    regWr(4'd8, 32'h3);
    regRd(4'd8, d); chk("R10 ctrl readback both", d, 32'h3);
    regWr(4'd8, 32'h0);
    chk("R10 demux cleared", 32'(demuxMode), 32'd0);

    // R8: formatter empty lags acceptance by one cycle
    regWr(4'd8, 32'h1);
    @(negedge clk);
    frameValid = 1'b1; frameData = frameVal(frameIdx);
    @(negedge clk);
    frameValid = 1'b0;
    regAddr = 4'd3; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    chk("R8 empty low while pending", 32'(regRdData[3]), 32'd0);
    regRd(4'd3, d); chk("R8 empty high after write", 32'(d[3]), 32'd1);
    regWr(4'd8, 32'h0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule